// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on a single TXD line. Each frame has a low start bit, then 5 to 9 data bits in either bit order, then an optional parity or address/data slot, then 1, 1.5 or 2 high stop bits. The line rests high between frames. A one-cycle baud tick comes from outside at sixteen times the bit rate. Every full bit lasts 16 ticks, and a half stop bit lasts 8 ticks.

Characters arrive on a valid/ready interface. The format fields are captured when a character is accepted and do not change until its frame has finished. A channel-mode input selects what appears on TXD and what is passed to the receiver path: the transmitter itself, the RXD pin, or a constant idle level. This supports echo and the two loopback tests. A busy output is high from the cycle a character is accepted until its last stop tick.

Top module: `async_serial_tx`

## Requirements
- R1: After reset, with channel mode 00, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame is a 0 start bit, then the data bits, then the optional parity slot, then stop bits at 1. Every start, data and parity bit lasts exactly 16 baud ticks. The frame advances only on cycles where `baud_tick` is 1.
- R3: With `cfg_nine` = 0, `cfg_len` values 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits, taken from the low bits of `in_data`. With `cfg_nine` = 1, the character is all 9 bits of `in_data`.
- R4: With `cfg_msb_first` = 0, the character is sent least significant bit first. With `cfg_msb_first` = 1, its most significant sent bit goes first.
- R5: `cfg_parity` selects the parity slot, computed over the data bits actually sent. 000 gives even parity and 001 gives odd parity. 010 sends a constant 0 and 011 sends a constant 1. 100 and 101 send no parity slot.
- R6: `cfg_parity` 110 or 111 selects multidrop. The parity slot then carries `in_addr_flag`, sampled with the character.
- R7: The stop phase lasts 16 ticks for `cfg_stop` 00, 24 ticks for 01, 32 ticks for 10 and 16 ticks for the reserved code 11.
- R8: Format fields that change after a character has been accepted have no effect on that character's frame.
- R9: `in_ready` is 1 only when no frame is in progress and the channel mode is not 11. A character is taken on a cycle where both `in_valid` and `in_ready` are 1. `busy` then stays high for exactly the length of the frame.
- R10: Channel mode 00 drives the transmitter onto `txd` and passes `rxd` to `rx_path`. Mode 01 (echo) drives `rxd` onto `txd` and also passes it to `rx_path`.
- R11: Channel mode 10 (local loopback) holds `txd` at 1 and feeds the transmitter line to `rx_path`.
- R12: Channel mode 11 (remote loopback) drives `rxd` onto `txd`, holds `rx_path` at 1 and keeps `in_ready` at 0, so no character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Data length code for 5 to 8 bits |
| cfg_nine | input | 1 | Selects 9-bit characters |
| cfg_msb_first | input | 1 | Bit order: 1 sends the most significant bit first |
| cfg_parity | input | 3 | Parity slot mode |
| cfg_stop | input | 2 | Stop length code |
| cfg_chan | input | 2 | Channel routing mode |
| in_valid | input | 1 | A character is offered |
| in_data | input | 9 | Character bits |
| in_addr_flag | input | 1 | Address/data flag used in multidrop mode |
| in_ready | output | 1 | A character can be accepted |
| busy | output | 1 | A frame is in progress |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |
| rx_path | output | 1 | Routed input to the receiver |

## Verification
The assertions take for granted that `baud_tick` is a clean one-cycle level sampled at the clock edge. They also assume the channel mode is not switched into remote loopback while a frame is in progress. The stimulus changes the channel mode only while `busy` is low. It keeps `baud_tick` high continuously except during one deliberate stall, so every tick boundary falls on a known cycle. Format fields are changed mid-frame only in the one scenario that checks they are ignored.

// File: rtl/ftx_pkg.sv
// Shared types for the asynchronous serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package ftx_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_ECHO   = 2'b01,
        CH_LOCAL  = 2'b10,
        CH_REMOTE = 2'b11
    } chan_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } ser_state_e;

    // Number of half-bit stop periods for a stop code (reserved code gives one bit).
    function automatic logic [2:0] stop_halves(input logic [1:0] code);
        case (code)
            2'b01:   return 3'd3;
            2'b10:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/ftx_framer.sv
// Builds the bits that follow the start bit: the ordered character bits and
// the optional parity/address slot. It also works out how many such bits there
// are and how many ticks the stop phase lasts.
// Assumes: MAXW >= 8 and OVS even; the inputs are valid in the accept cycle.
module ftx_framer #(
    parameter int MAXW = 9,
    parameter int OVS  = 16,
    localparam int PW  = MAXW + 1,
    localparam int CW  = $clog2(PW + 1),
    localparam int TW  = $clog2(2 * OVS + 1)
) (
    input  logic [1:0]      cfg_len,
    input  logic            cfg_nine,
    input  logic            cfg_msb_first,
    input  logic [2:0]      cfg_parity,
    input  logic [1:0]      cfg_stop,
    input  logic [MAXW-1:0] data_i,
    input  logic            flag_i,
    output logic [PW-1:0]   payload_o,
    output logic [CW-1:0]   count_o,
    output logic [TW-1:0]   stop_lim_o
);
    import ftx_pkg::*;

    logic [CW-1:0]   nbits;
    logic [MAXW-1:0] masked;
    logic [MAXW-1:0] ordered;
    logic            par_bit;
    logic            has_par;

    // Character length and the bits in sending order.
    always_comb begin
        nbits   = cfg_nine ? CW'(MAXW) : CW'(5) + CW'(cfg_len);
        masked  = '0;
        ordered = '0;
        for (int i = 0; i < MAXW; i++) begin
            if (i < int'(nbits)) begin
                masked[i] = data_i[i];
                if (!cfg_msb_first) begin
                    ordered[i] = data_i[i];
                end else begin
                    for (int j = 0; j < MAXW; j++) begin
                        if (j == int'(nbits) - 1 - i) ordered[i] = data_i[j];
                    end
                end
            end
        end
    end

    // Parity slot contents and presence.
    always_comb begin
        has_par = 1'b1;
        par_bit = 1'b0;
        casez (cfg_parity)
            3'b000:  par_bit = ^masked;
            3'b001:  par_bit = ~^masked;
            3'b010:  par_bit = 1'b0;
            3'b011:  par_bit = 1'b1;
            3'b10?:  has_par = 1'b0;
            default: par_bit = flag_i;
        endcase
    end

    // Pack the payload, its length and the stop-phase tick limit.
    always_comb begin
        payload_o = {1'b0, ordered};
        if (has_par) payload_o[nbits] = par_bit;
        count_o    = nbits + CW'(has_par);
        stop_lim_o = TW'(stop_halves(cfg_stop)) * TW'(OVS / 2);
    end

endmodule

// File: rtl/ftx_serializer.sv
// Frame timing engine. It holds the payload captured at accept and steps
// through start, payload and stop, moving on after each full count of baud ticks.
// Assumes: count_i >= 1 and stop_lim_i >= 1 in the accept cycle.
module ftx_serializer #(
    parameter int MAXW = 9,
    parameter int OVS  = 16,
    localparam int PW  = MAXW + 1,
    localparam int CW  = $clog2(PW + 1),
    localparam int TW  = $clog2(2 * OVS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          accept,
    input  logic [PW-1:0] payload_i,
    input  logic [CW-1:0] count_i,
    input  logic [TW-1:0] stop_lim_i,
    output logic          line_o,
    output logic          busy_o
);
    import ftx_pkg::*;

    ser_state_e    state;
    logic [PW-1:0] shreg;
    logic [CW-1:0] left;
    logic [TW-1:0] tcnt;
    logic [TW-1:0] lim_q;

    // Frame sequencing and tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            shreg <= '0;
            left  <= '0;
            tcnt  <= '0;
            lim_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_START;
                        shreg <= payload_i;
                        left  <= count_i;
                        lim_q <= stop_lim_i;
                        tcnt  <= '0;
                    end
                end
                ST_START: begin
                    if (baud_tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt  <= '0;
                            state <= ST_BITS;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_BITS: begin
                    if (baud_tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt  <= '0;
                            shreg <= shreg >> 1;
                            left  <= left - 1'b1;
                            if (left == CW'(1)) state <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (baud_tick) begin
                        if (tcnt == lim_q - 1'b1) begin
                            tcnt  <= '0;
                            state <= ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Line level for the current phase.
    always_comb begin
        case (state)
            ST_START: line_o = 1'b0;
            ST_BITS:  line_o = shreg[0];
            default:  line_o = 1'b1;
        endcase
        busy_o = (state != ST_IDLE);
    end

    // R2: without a tick, an ongoing frame holds its line level.
    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !baud_tick) |=> $stable(line_o));

    // R7: the stop counter never passes the captured limit.
    p_stop_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (tcnt < lim_q));

    // R9: an accepted character starts a frame on the next cycle.
    p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_o && !line_o));

endmodule

// File: rtl/ftx_router.sv
// Channel routing between the transmitter line, the TXD pin, the RXD pin and
// the receiver path.
// Assumes: purely combinational; the mode is quasi-static.
module ftx_router (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] chan_i,
    input  logic       tx_line_i,
    input  logic       rxd_i,
    output logic       txd_o,
    output logic       rx_path_o
);
    import ftx_pkg::*;

    // Select the pin and receiver sources for the mode.
    always_comb begin
        case (chan_e'(chan_i))
            CH_ECHO: begin
                txd_o     = rxd_i;
                rx_path_o = rxd_i;
            end
            CH_LOCAL: begin
                txd_o     = 1'b1;
                rx_path_o = tx_line_i;
            end
            CH_REMOTE: begin
                txd_o     = rxd_i;
                rx_path_o = 1'b1;
            end
            default: begin
                txd_o     = tx_line_i;
                rx_path_o = rxd_i;
            end
        endcase
    end

    // R11: local loopback keeps the pin idle whatever the transmitter does.
    p_local_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_i == CH_LOCAL) |-> txd_o);

endmodule

// File: rtl/async_serial_tx.sv
// Top level of the configurable asynchronous serial transmitter. It accepts
// characters on a valid/ready interface, frames them with the format fields
// captured at accept, and routes TXD and the receiver path by channel mode.
// Assumes: baud_tick pulses at 16x the bit rate; the channel mode changes only while idle.
module async_serial_tx #(
    parameter int MAXW = 9,
    parameter int OVS  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  logic [1:0]      cfg_len,
    input  logic            cfg_nine,
    input  logic            cfg_msb_first,
    input  logic [2:0]      cfg_parity,
    input  logic [1:0]      cfg_stop,
    input  logic [1:0]      cfg_chan,
    input  logic            in_valid,
    input  logic [MAXW-1:0] in_data,
    input  logic            in_addr_flag,
    output logic            in_ready,
    output logic            busy,
    input  logic            rxd,
    output logic            txd,
    output logic            rx_path
);
    import ftx_pkg::*;

    localparam int PW = MAXW + 1;
    localparam int CW = $clog2(PW + 1);
    localparam int TW = $clog2(2 * OVS + 1);

    logic [PW-1:0] payload;
    logic [CW-1:0] count;
    logic [TW-1:0] stop_lim;
    logic          tx_line;
    logic          accept;

    // Handshake: accept only when idle and not in remote loopback.
    always_comb begin
        in_ready = !busy && (cfg_chan != CH_REMOTE);
        accept   = in_valid && in_ready;
    end

    ftx_framer #(.MAXW(MAXW), .OVS(OVS)) u_framer (
        .cfg_len       (cfg_len),
        .cfg_nine      (cfg_nine),
        .cfg_msb_first (cfg_msb_first),
        .cfg_parity    (cfg_parity),
        .cfg_stop      (cfg_stop),
        .data_i        (in_data),
        .flag_i        (in_addr_flag),
        .payload_o     (payload),
        .count_o       (count),
        .stop_lim_o    (stop_lim)
    );

    ftx_serializer #(.MAXW(MAXW), .OVS(OVS)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .accept     (accept),
        .payload_i  (payload),
        .count_i    (count),
        .stop_lim_i (stop_lim),
        .line_o     (tx_line),
        .busy_o     (busy)
    );

    ftx_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_i    (cfg_chan),
        .tx_line_i (tx_line),
        .rxd_i     (rxd),
        .txd_o     (txd),
        .rx_path_o (rx_path)
    );

    // R1: with no frame in progress in normal mode, the pin rests high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_chan == CH_NORMAL) |-> txd);

    // R12: remote loopback never offers ready.
    p_remote_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chan == CH_REMOTE) |-> !in_ready);

    // R9: no new character is taken while a frame runs.
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

endmodule

// File: tb/async_serial_tx_test.sv
`timescale 1ns/1ps
module async_serial_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_nine = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [2:0] cfg_parity = 3'b100;
    logic [1:0] cfg_stop = 2'b00;
    logic [1:0] cfg_chan = 2'b00;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_addr_flag = 1'b0;
    logic       in_ready;
    logic       busy;
    logic       rxd = 1'b1;
    logic       txd;
    logic       rx_path;

    int checks = 0;
    int errors = 0;

    async_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_msb_first(cfg_msb_first),
        .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_chan(cfg_chan),
        .in_valid(in_valid), .in_data(in_data), .in_addr_flag(in_addr_flag),
        .in_ready(in_ready), .busy(busy), .rxd(rxd), .txd(txd), .rx_path(rx_path)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Send one character and check its frame bit by bit and its length.
    task automatic send(input string tag, input logic [1:0] ch, input logic [1:0] len,
                        input logic nine, input logic msb, input logic [2:0] par,
                        input logic [1:0] stp, input logic [8:0] d, input logic fl,
                        input bit disturb, input bit stall);
        logic [10:0] exp_bits;
        logic [10:0] got;
        logic        p;
        logic        obs;
        bit          hp;
        bit          pin_bad;
        int          nb, n, halves, shift, total, busy_cnt, ones;
        nb = nine ? 9 : 5 + int'(len);
        exp_bits = '0;
        ones = 0;
        for (int k = 0; k < nb; k++) begin
            exp_bits[1 + k] = msb ? d[nb - 1 - k] : d[k];
            ones += int'(d[k]);
        end
        hp = (par[2:1] != 2'b10);
        case (par)
            3'b000:  p = (ones % 2) == 1;
            3'b001:  p = (ones % 2) == 0;
            3'b010:  p = 1'b0;
            3'b011:  p = 1'b1;
            default: p = fl;
        endcase
        n = 1 + nb;
        if (hp) begin
            exp_bits[n] = p;
            n++;
        end
        halves = (stp == 2'b01) ? 3 : (stp == 2'b10) ? 4 : 2;
        shift  = stall ? 40 : 0;
        total  = 16 * n + 8 * halves + shift;
        @(negedge clk);
        cfg_chan = ch; cfg_len = len; cfg_nine = nine; cfg_msb_first = msb;
        cfg_parity = par; cfg_stop = stp; in_data = d; in_addr_flag = fl;
        in_valid = 1'b1;
        #1 check({tag, " R9 ready before accept"}, in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        got = '0; busy_cnt = 0; pin_bad = 0;
        for (int i = 0; i < total + 40; i++) begin
            if (stall) baud_tick = !(i >= 3 && i < 43);
            if (disturb && i == 20) begin
                cfg_len = ~len; cfg_msb_first = ~msb; cfg_nine = ~nine;
                cfg_parity = par ^ 3'b001; cfg_stop = stp ^ 2'b11;
            end
            #1;
            obs = (ch == 2'b10) ? rx_path : txd;
            if (ch == 2'b10 && txd !== 1'b1) pin_bad = 1;
            for (int k = 0; k < n; k++)
                if (i == 16 * k + 8 + shift) got[k] = obs;
            if (i == 16 * n + 4 + shift) check({tag, " R2 stop level"}, obs, 1);
            if (i == 5) check({tag, " R9 ready low while busy"}, in_ready, 0);
            if (busy) busy_cnt++;
            @(negedge clk);
        end
        baud_tick = 1'b1;
        check({tag, " R2 R3 R4 R5 frame bits"}, 32'(got), 32'(exp_bits));
        check({tag, " R7 R9 frame length"}, busy_cnt, total);
        if (ch == 2'b10) check({tag, " R11 pin idle"}, pin_bad, 0);
        cfg_chan = 2'b00;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 txd idle", txd, 1);
        check("R1 busy", busy, 0);
        check("R1 ready", in_ready, 1);
    endtask

    // Routing modes while idle, and remote loopback refusing characters.
    task automatic t_routing();
        for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            rxd = v[0]; cfg_chan = 2'b00;
            #1 check("R10 normal rx_path", rx_path, v[0]);
            check("R10 normal txd", txd, 1);
            cfg_chan = 2'b01;
            #1 check("R10 echo txd", txd, v[0]);
            check("R10 echo rx_path", rx_path, v[0]);
            cfg_chan = 2'b10;
            #1 check("R11 local txd", txd, 1);
            cfg_chan = 2'b11;
            #1 check("R12 remote txd", txd, v[0]);
            check("R12 remote rx_path", rx_path, 1);
        end
        in_valid = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check("R12 remote ready", in_ready, 0);
            check("R12 remote no frame", busy, 0);
        end
        in_valid = 1'b0;
        cfg_chan = 2'b00;
        rxd = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        send("8N1 lsb",            2'b00, 2'b11, 0, 0, 3'b100, 2'b00, 9'h0A5, 0, 0, 0);
        send("5 even",             2'b00, 2'b00, 0, 0, 3'b000, 2'b00, 9'h013, 0, 0, 0);
        send("7 odd msb R4",       2'b00, 2'b10, 0, 1, 3'b001, 2'b00, 9'h05A, 0, 0, 0);
        send("6 space 1.5stop R7", 2'b00, 2'b01, 0, 0, 3'b010, 2'b01, 9'h02D, 0, 0, 0);
        send("8 mark 2stop R7",    2'b00, 2'b11, 0, 0, 3'b011, 2'b10, 9'h0C3, 0, 0, 0);
        send("9 multidrop R6",     2'b00, 2'b00, 1, 1, 3'b110, 2'b11, 9'h14B, 1, 0, 0);
        send("9 multidrop0 R6",    2'b00, 2'b00, 1, 0, 3'b111, 2'b00, 9'h0F0, 0, 0, 0);
        send("9 none R3",          2'b00, 2'b01, 1, 0, 3'b101, 2'b00, 9'h1E1, 0, 0, 0);
        send("disturb R8",         2'b00, 2'b11, 0, 0, 3'b000, 2'b00, 9'h037, 0, 1, 0);
        send("stall R2",           2'b00, 2'b10, 0, 0, 3'b001, 2'b00, 9'h046, 0, 0, 1);
        send("local R11",          2'b10, 2'b11, 0, 0, 3'b000, 2'b00, 9'h096, 0, 0, 0);
        t_routing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule